// File: doc/BRIEF.md
# LCD Panel Raster Timing Generator

This block drives the timing side of a parallel TFT panel. A small word-addressed register port holds the panel geometry, the pixel clock divide ratio, the active level of each sync output and the end-of-frame interrupt controls. From these settings the block produces a pixel-clock enable, line sync, frame sync, a data-enable window and the coordinates of the pixel being shown. It also raises an end-of-frame interrupt that software can mask and acknowledge.

Each line runs through four phases in a fixed order: sync pulse, back porch, active pixels, front porch. Frames step through the same four phases, one line at a time. The horizontal fields use offset encodings that a driver must apply. The sync width and the front porch are each written as the count minus one. The back porch is written as the count minus three. The active width is written in units of sixteen pixels. The vertical fields take plain line counts. All geometry, divider and polarity settings are copied into a working set at the frame boundary. A frame that is already running therefore always finishes with the settings it started with.

Top module: `lcd_timing_gen`

## Requirements
- R1: After reset every register reads zero, `irq` is low, `dataEn` is low and `vSync` is low.
- R2: Word addresses are 0 size, 1 horizontal, 2 vertical, 3 panel, 4 interrupt enable and 5 interrupt status. Addresses 0 to 4 read back the full 32-bit word last written. Address 5 reads the status flag in bit 1 and zero elsewhere.
- R3: `pixEn` is high for one clock in every N clocks, where N is panel bits [5:0] plus one.
- R4: Each line has the following phases, each counted in `pixEn` cycles. The sync pulse lasts horizontal bits [31:26] plus 1. The back porch lasts bits [7:0] plus 3. The active phase lasts 16 times size bits [25:20]. The front porch lasts bits [15:8] plus 1.
- R5: The vertical position advances once per completed line. A frame has a sync phase of vertical bits [31:26] lines, then a back porch of bits [7:0] lines, then size bits [9:0] active lines, then a front porch of bits [15:8] lines.
- R6: `dataEn` is active only when the line and the frame are both in their active phase. Inside that window, `pixX` and `pixY` count from 0 at the first active pixel and the first active line. Outside it they read 0.
- R7: When panel bit 22 is set, `hSync` is active low. When bit 23 is set, `vSync` is active low. When bit 20 is set, `dataEn` is active low. When a bit is clear, its output is active high.
- R8: The status flag (bit 1) is set on the clock after the last pixel clock of the last active line. It stays set until a write to address 5 with bit 1 set. A write with bit 1 clear has no effect on it. If a set and a clear arrive in the same clock, the set wins.
- R9: `irq` is high exactly when the status flag and interrupt-enable bit 1 are both set. The flag is set whatever the enable bit holds.
- R10: Writes to the size, horizontal, vertical and panel registers take effect at the first pixel of the next frame. The frame that is running completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` |
| pixEn | output | 1 | Pixel clock enable |
| hSync | output | 1 | Line sync, level set by R7 |
| vSync | output | 1 | Frame sync, level set by R7 |
| dataEn | output | 1 | Data-enable window, level set by R7 |
| pixX | output | H_CNT_W | Active pixel column |
| pixY | output | V_CNT_W | Active line number |
| irq | output | 1 | End-of-frame interrupt |

## Verification
The raster is compared pixel clock by pixel clock against a model built from the field rules. Two geometries are used. The first has a divide ratio of two, non-inverted outputs and a single front-porch line. The second has a divide ratio of one, all three outputs inverted, zero vertical back and front porch, and a two-line sync. Running both tells the plus-one, plus-three and times-sixteen offsets apart from the raw vertical counts, and shows the inversion bits acting on each output separately. The second geometry is written while the first frame is still running, and the expected streams are joined with no gap. Any early or late switch of settings therefore shows up as a mismatch at the exact frame seam. The interrupt checks cover four cases: the flag set while masked, a write of zero, unmasking and acknowledging. They also pin down the single clock on which the flag rises.

// File: rtl/lcdt_pkg.sv
`timescale 1ns/1ps
package lcdt_pkg;
  localparam int REG_AW = 3;
  localparam logic [REG_AW-1:0] ADR_SIZE  = 3'd0;
  localparam logic [REG_AW-1:0] ADR_HORZ  = 3'd1;
  localparam logic [REG_AW-1:0] ADR_VERT  = 3'd2;
  localparam logic [REG_AW-1:0] ADR_PANEL = 3'd3;
  localparam logic [REG_AW-1:0] ADR_IEN   = 3'd4;
  localparam logic [REG_AW-1:0] ADR_ISTAT = 3'd5;

  localparam int EOF_BIT    = 1;
  localparam int POL_DE_BIT = 20;
  localparam int POL_HS_BIT = 22;
  localparam int POL_VS_BIT = 23;

  // packed field layout shared by the timing words
  localparam int SYNC_LSB = 26, SYNC_FW = 6;
  localparam int FP_LSB   = 8,  FP_FW   = 8;
  localparam int BP_LSB   = 0,  BP_FW   = 8;
  localparam int WID_LSB  = 20, WID_FW  = 6;
  localparam int LIN_LSB  = 0,  LIN_FW  = 10;
  localparam int DIV_LSB  = 0,  DIV_FW  = 6;

  // working geometry handed from control to datapath
  typedef struct packed {
    logic [DIV_FW-1:0]  divM1;
    logic               polHs;
    logic               polVs;
    logic               polDe;
    logic [SYNC_FW-1:0] hSyncF;
    logic [BP_FW-1:0]   hBpF;
    logic [WID_FW-1:0]  hActF;
    logic [FP_FW-1:0]   hFpF;
    logic [SYNC_FW-1:0] vSyncN;
    logic [BP_FW-1:0]   vBpN;
    logic [LIN_FW-1:0]  vActN;
    logic [FP_FW-1:0]   vFpN;
  } geom_t;

  // strobes returned from datapath to control
  typedef struct packed {
    logic frameWrap;
    logic activeDone;
  } evt_t;
endpackage

// File: rtl/lcdt_path.sv
`timescale 1ns/1ps
module lcdt_path
  import lcdt_pkg::*;
#(
  parameter int H_CNT_W = 12,
  parameter int V_CNT_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  geom_t              geom,
  output logic               pixEn,
  output logic               hSync,
  output logic               vSync,
  output logic               dataEn,
  output logic [H_CNT_W-1:0] pixX,
  output logic [V_CNT_W-1:0] pixY,
  output evt_t               evt
);
  localparam logic [H_CNT_W-1:0] H_ONE   = H_CNT_W'(1);
  localparam logic [H_CNT_W-1:0] H_THREE = H_CNT_W'(3);
  localparam logic [V_CNT_W-1:0] V_ONE   = V_CNT_W'(1);
  localparam logic [DIV_FW-1:0]  D_ONE   = DIV_FW'(1);

  logic [DIV_FW-1:0]  divCnt;
  logic [H_CNT_W-1:0] hCnt;
  logic [V_CNT_W-1:0] vCnt;

  // decoded line phases
  logic [H_CNT_W-1:0] hSyncLen, hBpLen, hActLen, hFpLen;
  logic [H_CNT_W-1:0] hActStart, hActEnd, hLast;
  logic [V_CNT_W-1:0] vSyncLen, vActStart, vActEnd, vTotal, vLast, vLastAct;

  always_comb begin
    hSyncLen  = H_CNT_W'(geom.hSyncF) + H_ONE;
    hBpLen    = H_CNT_W'(geom.hBpF) + H_THREE;
    hActLen   = H_CNT_W'(geom.hActF) << 4;
    hFpLen    = H_CNT_W'(geom.hFpF) + H_ONE;
    hActStart = hSyncLen + hBpLen;
    hActEnd   = hActStart + hActLen;
    hLast     = hActEnd + hFpLen - H_ONE;

    vSyncLen  = V_CNT_W'(geom.vSyncN);
    vActStart = vSyncLen + V_CNT_W'(geom.vBpN);
    vActEnd   = vActStart + V_CNT_W'(geom.vActN);
    vTotal    = vActEnd + V_CNT_W'(geom.vFpN);
    vLast     = (vTotal == '0) ? '0 : vTotal - V_ONE;
    vLastAct  = vActEnd - V_ONE;
  end

  // pixel clock divider
  assign pixEn = (divCnt >= geom.divM1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     divCnt <= '0;
    else if (pixEn) divCnt <= '0;
    else            divCnt <= divCnt + D_ONE;
  end

  logic lineEnd;
  assign lineEnd        = pixEn && (hCnt >= hLast);
  assign evt.frameWrap  = lineEnd && (vCnt >= vLast);
  assign evt.activeDone = lineEnd && (geom.vActN != '0) && (vCnt == vLastAct);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (pixEn) begin
      hCnt <= lineEnd ? '0 : hCnt + H_ONE;
      if (lineEnd) vCnt <= evt.frameWrap ? '0 : vCnt + V_ONE;
    end
  end

  logic hInSync, vInSync, hInAct, vInAct, deRaw;
  assign hInSync = (hCnt < hSyncLen);
  assign vInSync = (vCnt < vSyncLen);
  assign hInAct  = (hCnt >= hActStart) && (hCnt < hActEnd);
  assign vInAct  = (vCnt >= vActStart) && (vCnt < vActEnd);
  assign deRaw   = hInAct && vInAct;

  assign hSync  = hInSync ^ geom.polHs;
  assign vSync  = vInSync ^ geom.polVs;
  assign dataEn = deRaw ^ geom.polDe;
  assign pixX   = deRaw ? hCnt - hActStart : '0;
  assign pixY   = deRaw ? vCnt - vActStart : '0;

  // R4: position only moves on a pixel clock
  p_hold_between_ticks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !pixEn |=> $stable(hCnt));
  // R6: active window never overlaps the line sync
  p_de_outside_sync_r6: assert property (@(posedge clk) disable iff (!rst_n)
    deRaw |-> !hInSync);
  // R3: a ratio above one leaves a gap after every pixel clock
  p_div_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pixEn && !evt.frameWrap && geom.divM1 != '0) |=> !pixEn);
endmodule

// File: rtl/lcdt_ctrl.sv
`timescale 1ns/1ps
module lcdt_ctrl
  import lcdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  evt_t              evt,
  output geom_t             geomQ,
  output logic              irq
);
  logic [31:0] sizeReg, horzReg, vertReg, panelReg, ienReg;
  logic        statusBit;

  function automatic geom_t unpackGeom(logic [31:0] s, logic [31:0] h,
                                       logic [31:0] v, logic [31:0] p);
    geom_t g;
    g.divM1  = p[DIV_LSB +: DIV_FW];
    g.polHs  = p[POL_HS_BIT];
    g.polVs  = p[POL_VS_BIT];
    g.polDe  = p[POL_DE_BIT];
    g.hSyncF = h[SYNC_LSB +: SYNC_FW];
    g.hBpF   = h[BP_LSB +: BP_FW];
    g.hFpF   = h[FP_LSB +: FP_FW];
    g.hActF  = s[WID_LSB +: WID_FW];
    g.vSyncN = v[SYNC_LSB +: SYNC_FW];
    g.vBpN   = v[BP_LSB +: BP_FW];
    g.vFpN   = v[FP_LSB +: FP_FW];
    g.vActN  = s[LIN_LSB +: LIN_FW];
    return g;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sizeReg  <= '0;
      horzReg  <= '0;
      vertReg  <= '0;
      panelReg <= '0;
      ienReg   <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        ADR_SIZE:  sizeReg  <= regWrData;
        ADR_HORZ:  horzReg  <= regWrData;
        ADR_VERT:  vertReg  <= regWrData;
        ADR_PANEL: panelReg <= regWrData;
        ADR_IEN:   ienReg   <= regWrData;
        default: ;
      endcase
    end
  end

  // working copy reloads only at the frame seam
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             geomQ <= '0;
    else if (evt.frameWrap) geomQ <= unpackGeom(sizeReg, horzReg, vertReg, panelReg);
  end

  logic clrReq;
  assign clrReq = regWrEn && (regAddr == ADR_ISTAT) && regWrData[EOF_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              statusBit <= 1'b0;
    else if (evt.activeDone) statusBit <= 1'b1;
    else if (clrReq)         statusBit <= 1'b0;
  end

  assign irq = statusBit && ienReg[EOF_BIT];

  always_comb begin
    case (regAddr)
      ADR_SIZE:  regRdData = sizeReg;
      ADR_HORZ:  regRdData = horzReg;
      ADR_VERT:  regRdData = vertReg;
      ADR_PANEL: regRdData = panelReg;
      ADR_IEN:   regRdData = ienReg;
      ADR_ISTAT: regRdData = 32'(statusBit) << EOF_BIT;
      default:   regRdData = '0;
    endcase
  end

  // R10: working geometry frozen between frame seams
  p_shadow_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !evt.frameWrap |=> $stable(geomQ));
  // R8: flag follows the end of the last active line
  p_status_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evt.activeDone |=> statusBit);
  // R8: flag only drops on an acknowledge
  p_status_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (statusBit && !clrReq) |=> statusBit);
endmodule

// File: rtl/lcd_timing_gen.sv
`timescale 1ns/1ps
module lcd_timing_gen
  import lcdt_pkg::*;
#(
  parameter int H_CNT_W = 12,
  parameter int V_CNT_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               regWrEn,
  input  logic [2:0]         regAddr,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  output logic               pixEn,
  output logic               hSync,
  output logic               vSync,
  output logic               dataEn,
  output logic [H_CNT_W-1:0] pixX,
  output logic [V_CNT_W-1:0] pixY,
  output logic               irq
);
  geom_t geomQ;
  evt_t  evt;

  lcdt_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .evt(evt),
    .geomQ(geomQ), .irq(irq)
  );

  lcdt_path #(.H_CNT_W(H_CNT_W), .V_CNT_W(V_CNT_W)) u_path (
    .clk(clk), .rst_n(rst_n), .geom(geomQ), .pixEn(pixEn),
    .hSync(hSync), .vSync(vSync), .dataEn(dataEn),
    .pixX(pixX), .pixY(pixY), .evt(evt)
  );
endmodule

// File: tb/lcd_timing_gen_bench.sv
`timescale 1ns/1ps
module lcd_timing_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        pixEn, hSync, vSync, dataEn, irq;
  logic [11:0] pixX, pixY;

  always #5 clk = ~clk;

  lcd_timing_gen u_lcd_timing_gen (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .pixEn(pixEn),
    .hSync(hSync), .vSync(vSync), .dataEn(dataEn),
    .pixX(pixX), .pixY(pixY), .irq(irq)
  );

  typedef struct packed {
    logic hs, vs, de;
    logic [11:0] x, y;
    logic last;
  } item_t;

  item_t q[$];
  int nChecks = 0, nFails = 0;
  bit started = 0, irqPend = 0, irqArmed = 0, done = 0;
  logic prevVs = 1'b0;
  item_t e;

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  task automatic writeReg(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  // expected raster from the phase rules (plain counts, not field codes)
  task automatic pushFrame(int hs, int hb, int ha, int hf, int vs, int vb, int va, int vf,
                           bit pH, bit pV, bit pD);
    int hT = hs + hb + ha + hf;
    int vT = vs + vb + va + vf;
    for (int v = 0; v < vT; v++) begin
      for (int h = 0; h < hT; h++) begin
        item_t it;
        bit hAct = (h >= hs + hb) && (h < hs + hb + ha);
        bit vAct = (v >= vs + vb) && (v < vs + vb + va);
        it.hs = (h < hs) ^ pH;
        it.vs = (v < vs) ^ pV;
        it.de = (hAct && vAct) ^ pD;
        it.x = (hAct && vAct) ? 12'(h - hs - hb) : 12'd0;
        it.y = (hAct && vAct) ? 12'(v - vs - vb) : 12'd0;
        it.last = (v == vs + vb + va - 1) && (h == hT - 1);
        q.push_back(it);
      end
    end
  endtask

  task automatic measureSpacing(int exp, string req);
    int n;
    while (!pixEn) @(negedge clk);
    @(negedge clk);
    n = 1;
    while (!pixEn) begin @(negedge clk); n++; end
    check(req, n, exp);
  endtask

  // monitor: pops expected pixels as the raster is produced
  always @(negedge clk) begin
    if (irqPend) begin
      check("R8 R9 irq one clock after last active pixel", int'(irq), int'(irqArmed));
      irqPend = 0;
    end
    if (rst_n && pixEn) begin
      if (q.size() != 0) begin
        if (!started && vSync == q[0].vs && hSync == q[0].hs && prevVs != q[0].vs)
          started = 1;
        if (started) begin
          e = q.pop_front();
          check("R4 R7 hSync", int'(hSync), int'(e.hs));
          check("R5 R7 vSync", int'(vSync), int'(e.vs));
          check("R6 R7 dataEn", int'(dataEn), int'(e.de));
          check("R6 pixX", int'(pixX), int'(e.x));
          check("R6 pixY", int'(pixY), int'(e.y));
          if (e.last) begin
            check("R8 irq low at last active pixel", int'(irq), 0);
            irqPend = 1;
          end
          if (q.size() == 0) started = 0;
        end
      end
      prevVs = vSync;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      readReg(3'(a), rd);
      check("R1 register reset value", int'(rd), 0);
    end
    check("R1 irq after reset", int'(irq), 0);
    check("R1 dataEn after reset", int'(dataEn), 0);
    check("R1 vSync after reset", int'(vSync), 0);

    // geometry A: ratio 2, hsync 2, hbp 3, 16 active, hfp 2; 1/1/3/1 lines
    writeReg(3'd0, (32'd1 << 20) | 32'd3);
    writeReg(3'd1, (32'd1 << 26) | (32'd1 << 8) | 32'd0);
    writeReg(3'd2, (32'd1 << 26) | (32'd1 << 8) | 32'd1);
    writeReg(3'd3, 32'd1);
    readReg(3'd0, rd); check("R2 size readback", int'(rd), int'((32'd1 << 20) | 32'd3));
    readReg(3'd1, rd); check("R2 horizontal readback", int'(rd), int'((32'd1 << 26) | (32'd1 << 8)));
    readReg(3'd2, rd); check("R2 vertical readback", int'(rd), int'((32'd1 << 26) | (32'd1 << 8) | 32'd1));
    readReg(3'd3, rd); check("R2 panel readback", int'(rd), 1);
    repeat (60) @(negedge clk);
    measureSpacing(2, "R3 divide ratio two");

    irqArmed = 0;
    pushFrame(2, 3, 16, 2, 1, 1, 3, 1, 0, 0, 0);
    while (q.size() > 78) @(negedge clk);

    // geometry B written mid-frame (R10): ratio 1, 1/5/32/1, 2/0/2/0 lines, all inverted
    writeReg(3'd0, (32'd2 << 20) | 32'd2);
    writeReg(3'd1, 32'd2);
    writeReg(3'd2, (32'd2 << 26));
    writeReg(3'd3, (32'd1 << 20) | (32'd1 << 22) | (32'd1 << 23));
    pushFrame(1, 5, 32, 1, 2, 0, 2, 0, 1, 1, 1);
    while (q.size() > 150) @(negedge clk);

    // interrupt handling at the start of frame B (flag set by frame A)
    readReg(3'd5, rd);
    check("R8 flag set after frame", int'(rd), 2);
    check("R9 masked flag keeps irq low", int'(irq), 0);
    writeReg(3'd5, 32'd0);
    readReg(3'd5, rd);
    check("R8 zero write leaves flag", int'(rd), 2);
    writeReg(3'd4, 32'd2);
    check("R9 irq after enable", int'(irq), 1);
    writeReg(3'd5, 32'd2);
    check("R8 acknowledge drops irq", int'(irq), 0);
    readReg(3'd5, rd);
    check("R8 flag cleared", int'(rd), 0);
    irqArmed = 1;

    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    measureSpacing(1, "R3 divide ratio one");
    check("R9 irq held after frame B", int'(irq), 1);

    done = 1;
    summary();
    $finish;
  end
endmodule